// File: doc/BRIEF.md
# Static Memory Bus Controller

This block connects a simple host request port to a slow external parallel device such as a NOR flash or an asynchronous SRAM, for one chip-select region. The host presents an address, write data, an access size and a direction, and raises a valid flag. The block then runs one external cycle with programmable timing. It returns a one-cycle ready pulse, together with read data or an error flag.

Every external cycle passes through five phases in a fixed sequence: address, setup, strobe, hold and recovery. Each phase lasts one clock plus a programmable extension. Configuration inputs select the following:

- the extension of each phase;
- the strobe style: separate read and write strobes, or a read-not-write level with one data strobe;
- whether the address is also carried on the data bus;
- a 16-bit or 8-bit data path;
- write permission;
- the decoded region size.

An access that the configuration forbids is answered at once with an error and touches no external pin.

Top module: `smb_ctrl`

## Requirements
- R1: Phases run in the order address, setup, strobe, hold, recovery. The chip select is low only during setup, strobe and hold. While idle, the chip select and both strobes are high and the data bus is not driven.
- R2: Each phase lasts one clock plus its extension. Address, setup and hold extensions are 2-bit values (0 to 3). Strobe and recovery extensions are 4-bit values (0 to 15).
- R3: req_ready is high for one cycle. For an accepted access it comes exactly (5 + sum of the extensions) clocks after the accepting edge. The timing and mode settings are captured at acceptance, so later changes do not affect an access in progress.
- R4: A request gets req_ready together with rsp_err on the clock after acceptance, and drives no chip select or strobe, in any of these cases: the region is disabled; it is a write while writes are not permitted; cfg_style is a reserved code (10 or 11); it is a halfword in 8-bit mode; it is a byte write in 16-bit mode. Reads stay legal while writes are not permitted.
- R5: With cfg_style 00, bus_rd_n is low only during the strobe phase of a read, and bus_wr_n is low only during the strobe phase of a write. The two are never low together.
- R6: With cfg_style 01, bus_rd_n is a read-not-write level during the chip-select window: high for a read, low for a write, and high outside the window. bus_wr_n is a data strobe that is low during the strobe phase for either direction.
- R7: With cfg_muxed set, the low DATA_W bits of the region address are driven on bus_dq_out, with bus_dq_oe high, during the address phase.
- R8: req_half is 0 for a byte and 1 for a halfword. In 8-bit mode (cfg_narrow=1), read data comes from bus_dq_in[7:0], zero-extended, and write data goes on bus_dq_out[7:0]. In 16-bit mode, a byte read returns bus_dq_in[7:0] for an even address and bus_dq_in[15:8] for an odd address, zero-extended.
- R9: bus_addr carries req_addr masked to the region size of 2^(9+cfg_region) bytes. In 16-bit mode, bit 0 is forced to 0.
- R10: During a write, data is driven from setup through hold, and the value does not change across the end of the strobe and the hold phase.
- R11: During a read, the data bus is not driven outside a muxed address phase, and it is also undriven during recovery. Read data is the value on bus_dq_in in the last clock of the strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Region enable |
| cfg_ext_addr | input | 2 | Address phase extension |
| cfg_ext_setup | input | 2 | Setup phase extension |
| cfg_ext_strobe | input | 4 | Strobe phase extension |
| cfg_ext_hold | input | 2 | Hold phase extension |
| cfg_ext_recov | input | 4 | Recovery phase extension |
| cfg_style | input | 2 | 00 split strobes, 01 read-not-write plus data strobe, others reserved |
| cfg_region | input | 4 | Region size code N, size 2^(9+N) bytes |
| cfg_muxed | input | 1 | Address also on data bus in address phase |
| cfg_write_ok | input | 1 | Writes permitted |
| cfg_narrow | input | 1 | 1 = 8-bit data path, 0 = 16-bit |
| req_valid | input | 1 | Request present, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_half | input | 1 | 1 = halfword, 0 = byte |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with req_ready |
| rsp_err | output | 1 | Rejected access, valid with req_ready |
| bus_addr | output | ADDR_W | External address |
| bus_dq_out | output | DATA_W | Data bus output value |
| bus_dq_oe | output | 1 | Data bus output enable |
| bus_dq_in | input | DATA_W | Data bus input value |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_rd_n | output | 1 | Read strobe, or read-not-write level in style 01 |
| bus_wr_n | output | 1 | Write strobe, or data strobe in style 01 |

## Verification
A request raised before a clock edge is accepted at that edge. From the next clock on, each phase shows on the pins for its own length of one plus its extension. req_ready follows exactly 5 plus the sum of the extensions clocks after acceptance. A rejected request shows ready and error one clock after acceptance. The bench samples every pin at the falling edge of each clock after acceptance. It assigns each sample to a phase by the chip-select and strobe levels, and compares the per-phase counts and the total with sums computed from the programmed fields. The bench's device model shows valid read data only while the strobe is active, so a capture taken in any clock other than the last strobe clock returns a visibly wrong value.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int EXT_W       = 4;
    localparam int REGION_BASE = 9;

    localparam logic [1:0] STY_SPLIT = 2'b00;
    localparam logic [1:0] STY_RNW   = 2'b01;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RECOV
    } phase_e;

    typedef struct packed {
        logic [1:0] ext_addr;
        logic [1:0] ext_setup;
        logic [3:0] ext_strobe;
        logic [1:0] ext_hold;
        logic [3:0] ext_recov;
    } tim_t;

    typedef struct packed {
        tim_t       tim;
        logic [1:0] style;
        logic       muxed;
        logic       narrow;
        logic       wr_ok;
    } acc_cfg_t;

    function automatic logic [EXT_W-1:0] phase_ext(phase_e ph, tim_t t);
        case (ph)
            PH_ADDR:   phase_ext = {2'b00, t.ext_addr};
            PH_SETUP:  phase_ext = {2'b00, t.ext_setup};
            PH_STROBE: phase_ext = t.ext_strobe;
            PH_HOLD:   phase_ext = {2'b00, t.ext_hold};
            PH_RECOV:  phase_ext = t.ext_recov;
            default:   phase_ext = '0;
        endcase
    endfunction

endpackage

// File: rtl/smb_seq.sv
module smb_seq
    import smb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  tim_t   tim,
    output phase_e phase,
    output logic   last
);

    logic [EXT_W-1:0] cnt;
    phase_e           nxt;

    always_comb begin
        case (phase)
            PH_ADDR:   nxt = PH_SETUP;
            PH_SETUP:  nxt = PH_STROBE;
            PH_STROBE: nxt = PH_HOLD;
            PH_HOLD:   nxt = PH_RECOV;
            PH_RECOV:  nxt = PH_IDLE;
            default:   nxt = PH_ADDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (phase == PH_IDLE) begin
            if (start) begin
                phase <= PH_ADDR;
                cnt   <= phase_ext(PH_ADDR, tim);
            end
        end else if (cnt == '0) begin
            phase <= nxt;
            cnt   <= phase_ext(nxt, tim);
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (phase != PH_IDLE) && (cnt == '0);

    AST_ADDR_TO_SETUP: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_ADDR && phase != PH_ADDR) |-> phase == PH_SETUP); // R1
    AST_STROBE_TO_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(phase) == PH_STROBE && phase != PH_STROBE) |-> phase == PH_HOLD); // R1
    AST_PHASE_ENDS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase) && $past(phase) != PH_IDLE) |-> $past(cnt) == '0); // R2

endmodule

// File: rtl/smb_decode.sv
module smb_decode
    import smb_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              enable,
    input  logic              write_ok,
    input  logic [1:0]        style,
    input  logic [3:0]        region,
    input  logic              narrow,
    input  logic              is_write,
    input  logic              is_half,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              reject,
    output logic [ADDR_W-1:0] addr_out
);

    logic [ADDR_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            mask[i] = (i < REGION_BASE + int'(region));
        end
        if (!narrow) begin
            mask[0] = 1'b0;
        end
    end

    assign addr_out = addr_in & mask;

    assign reject = !enable
                  || (is_write && !write_ok)
                  || !(style == STY_SPLIT || style == STY_RNW)
                  || (narrow && is_half)
                  || (!narrow && is_write && !is_half);

endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
    import smb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic [1:0]        cfg_ext_addr,
    input  logic [1:0]        cfg_ext_setup,
    input  logic [3:0]        cfg_ext_strobe,
    input  logic [1:0]        cfg_ext_hold,
    input  logic [3:0]        cfg_ext_recov,
    input  logic [1:0]        cfg_style,
    input  logic [3:0]        cfg_region,
    input  logic              cfg_muxed,
    input  logic              cfg_write_ok,
    input  logic              cfg_narrow,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_half,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dq_out,
    output logic              bus_dq_oe,
    input  logic [DATA_W-1:0] bus_dq_in,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n
);

    localparam int LANE_W = DATA_W / 2;

    acc_cfg_t          cfg_live, cfg_q;
    tim_t              tim_use;
    phase_e            phase;
    logic              last;
    logic              reject;
    logic              start;
    logic [ADDR_W-1:0] dec_addr;
    logic [ADDR_W-1:0] q_addr;
    logic [DATA_W-1:0] q_wdata;
    logic              q_write, q_half, q_lane;
    logic [DATA_W-1:0] rd_fmt;
    logic              in_cs;

    assign cfg_live.tim.ext_addr   = cfg_ext_addr;
    assign cfg_live.tim.ext_setup  = cfg_ext_setup;
    assign cfg_live.tim.ext_strobe = cfg_ext_strobe;
    assign cfg_live.tim.ext_hold   = cfg_ext_hold;
    assign cfg_live.tim.ext_recov  = cfg_ext_recov;
    assign cfg_live.style          = cfg_style;
    assign cfg_live.muxed          = cfg_muxed;
    assign cfg_live.narrow         = cfg_narrow;
    assign cfg_live.wr_ok          = cfg_write_ok;

    smb_decode #(.ADDR_W(ADDR_W)) u_decode (
        .enable   (cfg_enable),
        .write_ok (cfg_write_ok),
        .style    (cfg_style),
        .region   (cfg_region),
        .narrow   (cfg_narrow),
        .is_write (req_write),
        .is_half  (req_half),
        .addr_in  (req_addr),
        .reject   (reject),
        .addr_out (dec_addr)
    );

    assign start   = req_valid && (phase == PH_IDLE) && !reject;
    assign tim_use = (phase == PH_IDLE) ? cfg_live.tim : cfg_q.tim;

    smb_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .tim   (tim_use),
        .phase (phase),
        .last  (last)
    );

    always_comb begin
        rd_fmt = '0;
        if (cfg_q.narrow) begin
            rd_fmt[LANE_W-1:0] = bus_dq_in[LANE_W-1:0];
        end else if (!q_half) begin
            rd_fmt[LANE_W-1:0] = q_lane ? bus_dq_in[DATA_W-1:LANE_W]
                                        : bus_dq_in[LANE_W-1:0];
        end else begin
            rd_fmt = bus_dq_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '0;
            q_addr    <= '0;
            q_wdata   <= '0;
            q_write   <= 1'b0;
            q_half    <= 1'b0;
            q_lane    <= 1'b0;
            req_ready <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            req_ready <= 1'b0;
            rsp_err   <= 1'b0;
            if (phase == PH_IDLE && req_valid) begin
                if (reject) begin
                    req_ready <= 1'b1;
                    rsp_err   <= 1'b1;
                    rsp_rdata <= '0;
                end else begin
                    cfg_q   <= cfg_live;
                    q_addr  <= dec_addr;
                    q_wdata <= req_wdata;
                    q_write <= req_write;
                    q_half  <= req_half;
                    q_lane  <= req_addr[0];
                end
            end
            if (phase == PH_STROBE && last && !q_write) begin
                rsp_rdata <= rd_fmt;
            end
            if (phase == PH_RECOV && last) begin
                req_ready <= 1'b1;
            end
        end
    end

    assign in_cs    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    assign bus_cs_n = !in_cs;
    assign bus_addr = (phase != PH_IDLE) ? q_addr : '0;

    always_comb begin
        if (cfg_q.style == STY_RNW) begin
            bus_rd_n = in_cs ? !q_write : 1'b1;
            bus_wr_n = !(phase == PH_STROBE);
        end else begin
            bus_rd_n = !(phase == PH_STROBE && !q_write);
            bus_wr_n = !(phase == PH_STROBE && q_write);
        end
    end

    always_comb begin
        bus_dq_oe  = 1'b0;
        bus_dq_out = '0;
        if (phase == PH_ADDR && cfg_q.muxed) begin
            bus_dq_oe  = 1'b1;
            bus_dq_out = q_addr[DATA_W-1:0];
        end else if (in_cs && q_write) begin
            bus_dq_oe = 1'b1;
            if (cfg_q.narrow) begin
                bus_dq_out[LANE_W-1:0] = q_wdata[LANE_W-1:0];
            end else begin
                bus_dq_out = q_wdata;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |-> (bus_cs_n && bus_rd_n && bus_wr_n && !bus_dq_oe)); // R1
    AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> req_ready); // R4
    AST_WRITE_PERMITTED: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE && q_write) |-> cfg_q.wr_ok); // R4
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.style == STY_SPLIT) |-> (bus_rd_n || bus_wr_n)); // R5
    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (q_write && phase == PH_HOLD) |-> (bus_dq_oe && $stable(bus_dq_out))); // R10
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (!q_write && phase != PH_IDLE && phase != PH_ADDR) |-> !bus_dq_oe); // R11

endmodule

// File: tb/smb_ctrl_bench.sv
module smb_ctrl_bench;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              cfg_enable = 1'b1;
    logic [1:0]        cfg_ext_addr = 2'd0, cfg_ext_setup = 2'd0, cfg_ext_hold = 2'd0;
    logic [3:0]        cfg_ext_strobe = 4'd0, cfg_ext_recov = 4'd0;
    logic [1:0]        cfg_style = 2'b00;
    logic [3:0]        cfg_region = 4'd15;
    logic              cfg_muxed = 1'b0, cfg_write_ok = 1'b1, cfg_narrow = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0, req_half = 1'b1;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              req_ready, rsp_err, bus_dq_oe, bus_cs_n, bus_rd_n, bus_wr_n;
    logic [DATA_W-1:0] rsp_rdata, bus_dq_out, bus_dq_in;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] rd_val = 16'h1234;
    logic              strobe_now;

    assign strobe_now = (cfg_style == 2'b01) ? !bus_wr_n : !bus_rd_n;
    assign bus_dq_in  = strobe_now ? rd_val : 16'hDEAD;

    smb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smb_ctrl (
        .clk(clk), .rst(rst),
        .cfg_enable(cfg_enable), .cfg_ext_addr(cfg_ext_addr), .cfg_ext_setup(cfg_ext_setup),
        .cfg_ext_strobe(cfg_ext_strobe), .cfg_ext_hold(cfg_ext_hold), .cfg_ext_recov(cfg_ext_recov),
        .cfg_style(cfg_style), .cfg_region(cfg_region), .cfg_muxed(cfg_muxed),
        .cfg_write_ok(cfg_write_ok), .cfg_narrow(cfg_narrow),
        .req_valid(req_valid), .req_write(req_write), .req_half(req_half),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .bus_addr(bus_addr), .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe),
        .bus_dq_in(bus_dq_in), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
    );

    int checks = 0;
    int errors = 0;

    int m_addr, m_setup, m_strobe, m_hold, m_recov, m_total, m_cs;
    int m_rdlow, m_wrlow, m_both, m_oe_cs_rd, m_oe_rec, m_mux_oe;
    logic [DATA_W-1:0] m_mux_dq, m_wd_cs, m_wd_hold, m_rdata;
    logic [ADDR_W-1:0] m_addr_seen;
    logic              m_err, m_wd_moved;
    logic              late_apply = 1'b0;
    logic [3:0]        late_strobe = 4'd0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int expected_total();
        return int'(cfg_ext_addr) + int'(cfg_ext_setup) + int'(cfg_ext_strobe)
             + int'(cfg_ext_hold) + int'(cfg_ext_recov) + 5;
    endfunction

    task automatic access(input logic wr, input logic half, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd);
        int  stage;
        bit  done;
        logic s_low;
        m_addr = 0; m_setup = 0; m_strobe = 0; m_hold = 0; m_recov = 0; m_total = 0; m_cs = 0;
        m_rdlow = 0; m_wrlow = 0; m_both = 0; m_oe_cs_rd = 0; m_oe_rec = 0; m_mux_oe = 0;
        m_mux_dq = '0; m_wd_cs = '0; m_wd_hold = '0; m_addr_seen = '0; m_wd_moved = 1'b0;
        m_err = 1'b0; m_rdata = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_half = half; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (late_apply) cfg_ext_strobe = late_strobe;
        stage = 0;
        done  = 1'b0;
        while (!done && m_total < 300) begin
            if (req_ready) begin
                m_err   = rsp_err;
                m_rdata = rsp_rdata;
                done    = 1'b1;
            end else begin
                s_low = (cfg_style == 2'b01) ? !bus_wr_n : (!bus_rd_n || !bus_wr_n);
                if (!bus_cs_n) begin
                    m_cs++;
                    m_addr_seen = bus_addr;
                    if (bus_dq_oe && !wr) m_oe_cs_rd++;
                end
                if (!bus_rd_n) m_rdlow++;
                if (!bus_wr_n) m_wrlow++;
                if (!bus_rd_n && !bus_wr_n) m_both++;
                if (bus_cs_n && stage == 0) begin
                    m_addr++;
                    if (bus_dq_oe) begin m_mux_oe++; m_mux_dq = bus_dq_out; end
                end else if (!bus_cs_n && !s_low && stage <= 1) begin
                    stage = 1; m_setup++;
                end else if (s_low) begin
                    stage = 2; m_strobe++;
                    m_wd_cs = bus_dq_out;
                end else if (!bus_cs_n) begin
                    stage = 3; m_hold++;
                    m_wd_hold = bus_dq_out;
                    if (bus_dq_out !== m_wd_cs) m_wd_moved = 1'b1;
                end else begin
                    stage = 4; m_recov++;
                    if (bus_dq_oe) m_oe_rec++;
                end
                m_total++;
                @(negedge clk);
            end
        end
        late_apply = 1'b0;
    endtask

    task automatic set_timing(input int a, input int s, input int t, input int h, input int r);
        cfg_ext_addr = 2'(a); cfg_ext_setup = 2'(s); cfg_ext_strobe = 4'(t);
        cfg_ext_hold = 2'(h); cfg_ext_recov = 4'(r);
    endtask

    task automatic t_reset();
        chk("R1 reset cs_n", 32'(bus_cs_n), 1);
        chk("R1 reset rd_n", 32'(bus_rd_n), 1);
        chk("R1 reset wr_n", 32'(bus_wr_n), 1);
        chk("R1 reset oe", 32'(bus_dq_oe), 0);
        chk("R3 reset ready", 32'(req_ready), 0);
    endtask

    task automatic t_timing(input int a, input int s, input int t, input int h, input int r);
        set_timing(a, s, t, h, r);
        rd_val = 16'h1000 + 16'(t);
        access(1'b0, 1'b1, 24'h000100, '0);
        chk("R2 address length", m_addr, a + 1);
        chk("R2 setup length", m_setup, s + 1);
        chk("R2 strobe length", m_strobe, t + 1);
        chk("R2 hold length", m_hold, h + 1);
        chk("R2 recovery length", m_recov, r + 1);
        chk("R3 ready latency", m_total, expected_total());
        chk("R1 cs window", m_cs, s + t + h + 3);
        chk("R11 read data", 32'(m_rdata), 32'(rd_val));
        chk("R11 read undriven", m_oe_cs_rd + m_oe_rec, 0);
        chk("R5 read strobe only", m_rdlow, t + 1);
        chk("R5 no write strobe on read", m_wrlow, 0);
        chk("R4 read not rejected", 32'(m_err), 0);
    endtask

    task automatic t_write();
        set_timing(1, 2, 3, 2, 1);
        cfg_write_ok = 1'b1;
        access(1'b1, 1'b1, 24'h000200, 16'hA55A);
        chk("R10 write data in strobe", 32'(m_wd_cs), 32'hA55A);
        chk("R10 write data in hold", 32'(m_wd_hold), 32'hA55A);
        chk("R10 write data stable", 32'(m_wd_moved), 0);
        chk("R5 write strobe length", m_wrlow, 4);
        chk("R5 no read strobe on write", m_rdlow, 0);
        chk("R5 strobes exclusive", m_both, 0);
        chk("R11 recovery undriven", m_oe_rec, 0);
        chk("R3 write latency", m_total, expected_total());
    endtask

    task automatic t_reject();
        set_timing(1, 1, 4, 1, 1);
        cfg_write_ok = 1'b0;
        access(1'b1, 1'b1, 24'h000010, 16'h5555);
        chk("R4 protected write error", 32'(m_err), 1);
        chk("R4 protected write latency", m_total, 0);
        chk("R4 protected write no strobe", m_wrlow + m_cs, 0);
        access(1'b0, 1'b1, 24'h000010, '0);
        chk("R4 read while protected ok", 32'(m_err), 0);
        cfg_write_ok = 1'b1;
        cfg_enable = 1'b0;
        access(1'b0, 1'b1, 24'h000010, '0);
        chk("R4 disabled region error", 32'(m_err), 1);
        chk("R4 disabled region quiet", m_cs + m_rdlow, 0);
        cfg_enable = 1'b1;
        cfg_style = 2'b10;
        access(1'b0, 1'b1, 24'h000010, '0);
        chk("R4 reserved style error", 32'(m_err), 1);
        cfg_style = 2'b00;
        cfg_narrow = 1'b1;
        access(1'b0, 1'b1, 24'h000010, '0);
        chk("R4 halfword in 8-bit error", 32'(m_err), 1);
        cfg_narrow = 1'b0;
        access(1'b1, 1'b0, 24'h000010, 16'h0011);
        chk("R4 byte write in 16-bit error", 32'(m_err), 1);
        chk("R4 byte write quiet", m_cs + m_wrlow, 0);
    endtask

    task automatic t_style_rnw();
        set_timing(0, 1, 2, 1, 0);
        cfg_style = 2'b01;
        rd_val = 16'h7E81;
        access(1'b0, 1'b1, 24'h000020, '0);
        chk("R6 rnw high on read", m_rdlow, 0);
        chk("R6 data strobe on read", m_wrlow, 3);
        chk("R6 read data", 32'(m_rdata), 32'h7E81);
        access(1'b1, 1'b1, 24'h000020, 16'h0F0F);
        chk("R6 rnw low over cs window", m_rdlow, 2 + 3 + 2);
        chk("R6 data strobe on write", m_wrlow, 3);
        chk("R6 latency", m_total, expected_total());
        cfg_style = 2'b00;
    endtask

    task automatic t_mux();
        set_timing(2, 0, 1, 0, 1);
        cfg_muxed = 1'b1;
        rd_val = 16'h4242;
        access(1'b0, 1'b1, 24'h12ABCE, '0);
        chk("R7 address on data bus", m_mux_oe, 3);
        chk("R7 muxed address value", 32'(m_mux_dq), 32'hABCE);
        chk("R7 read bus released", m_oe_cs_rd, 0);
        chk("R7 read data", 32'(m_rdata), 32'h4242);
        cfg_muxed = 1'b0;
    endtask

    task automatic t_width();
        set_timing(0, 0, 1, 0, 0);
        rd_val = 16'hBEEF;
        access(1'b0, 1'b0, 24'h000007, '0);
        chk("R8 odd byte read", 32'(m_rdata), 32'h00BE);
        chk("R9 bit0 cleared in 16-bit", 32'(m_addr_seen), 32'h000006);
        access(1'b0, 1'b0, 24'h000006, '0);
        chk("R8 even byte read", 32'(m_rdata), 32'h00EF);
        cfg_narrow = 1'b1;
        access(1'b0, 1'b0, 24'h000005, '0);
        chk("R8 narrow read low lane", 32'(m_rdata), 32'h00EF);
        chk("R9 bit0 kept in 8-bit", 32'(m_addr_seen), 32'h000005);
        access(1'b1, 1'b0, 24'h000005, 16'h773C);
        chk("R8 narrow write low lane", 32'(m_wd_cs), 32'h003C);
        cfg_narrow = 1'b0;
    endtask

    task automatic t_region();
        set_timing(0, 0, 0, 0, 0);
        cfg_region = 4'd0;
        access(1'b0, 1'b1, 24'hABCDEF, '0);
        chk("R9 smallest region", 32'(m_addr_seen), 32'h0001EE);
        cfg_region = 4'd3;
        access(1'b0, 1'b1, 24'hABCDEF, '0);
        chk("R9 region code 3", 32'(m_addr_seen), 32'h000DEE);
        cfg_region = 4'd15;
        access(1'b0, 1'b1, 24'hABCDEF, '0);
        chk("R9 largest region", 32'(m_addr_seen), 32'hABCDEE);
    endtask

    task automatic t_latch();
        set_timing(1, 1, 2, 1, 1);
        late_apply  = 1'b1;
        late_strobe = 4'd9;
        access(1'b0, 1'b1, 24'h000040, '0);
        chk("R3 config captured at accept", m_strobe, 3);
        chk("R3 latency with old config", m_total, 1 + 1 + 2 + 1 + 1 + 5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_timing(1, 1, 4, 1, 1);
        t_timing(0, 0, 0, 0, 0);
        t_timing(3, 3, 15, 3, 15);
        t_timing(2, 0, 7, 3, 9);
        t_write();
        t_reject();
        t_style_rnw();
        t_mux();
        t_width();
        t_region();
        t_latch();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule